// File: doc/BRIEF.md
# CAN Channel Interrupt Controller

This block gathers every interrupt source of a single CAN channel and turns them into five registered request lines: wake-up, error, bus-off, transmit-done and receive-done. Channel-level sources (wake-up, error, bus-off) each own one sticky status bit. Every message object owns a sticky transmit-done bit and a sticky receive-done bit. All the per-object bits of one kind are reduced onto a single request line.

Software never writes a mask register directly. The mask registers can only be read at their own addresses. A bit is turned on by writing 1 to a set alias and turned off by writing 1 to a clear alias. Status bits are acknowledged by writing 1 to a clear alias, either a whole vector at once or one object at a time. The host reaches all of this through a plain register bus: address, write data, write strobe and combinational read data. Event pulses arrive from the protocol engine and from the message storage.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset, all mask bits and all status bits are 0, and every request line is 0.
- R2: A 1 on an event input sets the matching status bit at the next clock edge. The bit then stays 1 until it is cleared through a clear alias.
- R3: Writing to a status clear alias (channel status clear 0x04, transmit status clear 0x09, receive status clear 0x0B) clears every status bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R5: Writing to a mask set alias (channel 0x01, object 0x06) sets every mask bit whose write-data bit is 1 and leaves the others unchanged. Channel mask bit order: 0 wake-up, 1 error, 2 bus-off, 3 transmit-done, 4 receive-done. The object mask holds one bit per object.
- R6: Writing to a mask clear alias (channel 0x02, object 0x07) clears every mask bit whose write-data bit is 1 and leaves the others unchanged.
- R7: The channel mask (0x00), object mask (0x05), channel status (0x03, bit 0 wake-up, 1 error, 2 bus-off), transmit status (0x08) and receive status (0x0A) read their state zero-extended. Writes to these addresses change nothing.
- R8: irq_wake, irq_err and irq_busoff each equal the value, one cycle earlier, of their channel status bit ANDed with the same-index channel mask bit.
- R9: irq_tx equals the value, one cycle earlier, of channel mask bit 3 ANDed with the OR over all objects of transmit status ANDed with the object mask.
- R10: irq_rx equals the value, one cycle earlier, of channel mask bit 4 ANDed with the OR over all objects of receive status ANDed with the object mask.
- R11: Reading 0x10+n returns object n's transmit-done bit in bit 0 and its receive-done bit in bit 1. Writing 0x20+n clears the transmit-done bit if write-data bit 0 is 1 and the receive-done bit if bit 1 is 1. Other bits have no effect.
- R12: The write-only aliases and all unmapped addresses read as 0, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| ev_wake | input | 1 | Wake-up event pulse |
| ev_err | input | 1 | Bus error event pulse |
| ev_busoff | input | 1 | Bus-off entry event pulse |
| ev_tx_done | input | 16 | Per-object transmit completion pulses |
| ev_rx_done | input | 16 | Per-object reception completion pulses |
| irq_wake | output | 1 | Wake-up request line |
| irq_err | output | 1 | Error request line |
| irq_busoff | output | 1 | Bus-off request line |
| irq_tx | output | 1 | Transmit-done request line |
| irq_rx | output | 1 | Receive-done request line |

## Verification
The bench targets the cycle in which an event and a write-one-to-clear hit the same bit. A design that gave the clear priority would lose that completion, and the request line would never rise for it. Writes of 0 to every alias, and writes to the read-only mask addresses, are checked for having no effect. A design that loaded the alias value as a plain value, or that let the read-only address write the mask, would corrupt the mask. The reduction is exercised with the transmit or receive status set only on objects whose mask bit is off, and with the channel-level transmit and receive gates off. A design that ORed before masking, or that skipped the channel gate, would raise irq_tx or irq_rx falsely. The one-cycle register delay on every line is checked each cycle. Per-object clears at 0x20+n must leave every other object's bits untouched.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int MAX_OBJ   = 16;
    localparam int N_CHAN    = 3;   // wake, error, bus-off
    localparam int N_LINES   = 5;

    localparam int LN_WAKE = 0;
    localparam int LN_ERR  = 1;
    localparam int LN_BOFF = 2;
    localparam int LN_TX   = 3;
    localparam int LN_RX   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CMASK      = 6'h00,
        A_CMASK_SET  = 6'h01,
        A_CMASK_CLR  = 6'h02,
        A_CSTAT      = 6'h03,
        A_CSTAT_CLR  = 6'h04,
        A_OMASK      = 6'h05,
        A_OMASK_SET  = 6'h06,
        A_OMASK_CLR  = 6'h07,
        A_TXSTAT     = 6'h08,
        A_TXSTAT_CLR = 6'h09,
        A_RXSTAT     = 6'h0A,
        A_RXSTAT_CLR = 6'h0B
    } reg_addr_e;

    localparam logic [1:0] OBJ_RD_PAGE  = 2'b01;  // 0x10..0x1F
    localparam logic [1:0] OBJ_CLR_PAGE = 2'b10;  // 0x20..0x2F

    typedef struct packed {
        logic rx;
        logic tx;
    } obj_flags_t;

    // Address lies in a per-object page and names an existing object.
    function automatic logic obj_hit(input logic [ADDR_W-1:0] a,
                                     input logic [1:0] page, input int n_obj);
        return (a[ADDR_W-1:4] == page) && (int'(a[3:0]) < n_obj);
    endfunction

endpackage

// File: rtl/cic_mask_reg.sv
module cic_mask_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_bits) & ~clr_bits;
    end

    // R5
    mask_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ((q & ~$past(q) & ~$past(set_bits)) == '0));

    // R6
    mask_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ((~q & $past(q) & ~$past(clr_bits)) == '0));

endmodule

// File: rtl/cic_sticky_reg.sv
module cic_sticky_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    // An event always beats a clear of the same bit.
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_bits) | ev;
    end

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(ev) & ~q) == '0));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((q & ~$past(q) & ~$past(ev)) == '0));

    // R3
    hold_unless_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(q) & ~$past(clr_bits) & ~q) == '0));

endmodule

// File: rtl/cic_irq_lines.sv
module cic_irq_lines
    import can_irq_pkg::*;
#(
    parameter int NUM_OBJ = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CHAN-1:0]  chan_stat,
    input  logic [N_LINES-1:0] chan_mask,
    input  logic [NUM_OBJ-1:0] tx_stat,
    input  logic [NUM_OBJ-1:0] rx_stat,
    input  logic [NUM_OBJ-1:0] obj_mask,
    output logic [N_LINES-1:0] irq_q
);

    logic [N_LINES-1:0] irq_d;

    genvar g;
    generate
        for (g = 0; g < N_CHAN; g++) begin : g_chan_line
            assign irq_d[g] = chan_stat[g] & chan_mask[g];
        end
    endgenerate

    assign irq_d[LN_TX] = chan_mask[LN_TX] & (|(tx_stat & obj_mask));
    assign irq_d[LN_RX] = chan_mask[LN_RX] & (|(rx_stat & obj_mask));

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_d;
    end

    // R9
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(chan_mask[LN_TX]) |-> !irq_q[LN_TX]);

    // R10
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(chan_mask[LN_RX]) |-> !irq_q[LN_RX]);

    // R9
    tx_no_source_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_stat) == '0) |-> !irq_q[LN_TX]);

endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
    import can_irq_pkg::*;
#(
    parameter int NUM_OBJ = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    input  logic              ev_wake,
    input  logic              ev_err,
    input  logic              ev_busoff,
    input  logic [15:0]       ev_tx_done,
    input  logic [15:0]       ev_rx_done,
    output logic              irq_wake,
    output logic              irq_err,
    output logic              irq_busoff,
    output logic              irq_tx,
    output logic              irq_rx
);

    localparam int OBJ_LAST = NUM_OBJ - 1;

    logic [N_LINES-1:0] cmask, cmask_set, cmask_clr;
    logic [N_CHAN-1:0]  cstat, cstat_ev, cstat_clr;
    logic [OBJ_LAST:0]  omask, omask_set, omask_clr;
    logic [OBJ_LAST:0]  tx_stat, tx_clr, rx_stat, rx_clr;
    logic [MAX_OBJ-1:0] tx_pad, rx_pad;
    logic [N_LINES-1:0] irq_vec;
    logic               wr_obj_clr, rd_obj;
    obj_flags_t         obj_rd;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:N_LINES];
    assign cstat_ev     = {ev_busoff, ev_err, ev_wake};
    assign wr_obj_clr   = reg_we && obj_hit(reg_addr, OBJ_CLR_PAGE, NUM_OBJ);
    assign rd_obj       = obj_hit(reg_addr, OBJ_RD_PAGE, NUM_OBJ);

    // Alias write decode
    always_comb begin
        cmask_set = '0;
        cmask_clr = '0;
        cstat_clr = '0;
        omask_set = '0;
        omask_clr = '0;
        tx_clr    = '0;
        rx_clr    = '0;
        if (reg_we) begin
            case (reg_addr)
                A_CMASK_SET:  cmask_set = reg_wdata[N_LINES-1:0];
                A_CMASK_CLR:  cmask_clr = reg_wdata[N_LINES-1:0];
                A_CSTAT_CLR:  cstat_clr = reg_wdata[N_CHAN-1:0];
                A_OMASK_SET:  omask_set = reg_wdata[OBJ_LAST:0];
                A_OMASK_CLR:  omask_clr = reg_wdata[OBJ_LAST:0];
                A_TXSTAT_CLR: tx_clr    = reg_wdata[OBJ_LAST:0];
                A_RXSTAT_CLR: rx_clr    = reg_wdata[OBJ_LAST:0];
                default: ;
            endcase
        end
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (wr_obj_clr && (reg_addr[3:0] == 4'(i))) begin
                tx_clr[i] = reg_wdata[0];
                rx_clr[i] = reg_wdata[1];
            end
        end
    end

    cic_mask_reg #(.W(N_LINES)) u_cmask (
        .clk(clk), .rst(rst), .set_bits(cmask_set), .clr_bits(cmask_clr), .q(cmask));

    cic_mask_reg #(.W(NUM_OBJ)) u_omask (
        .clk(clk), .rst(rst), .set_bits(omask_set), .clr_bits(omask_clr), .q(omask));

    cic_sticky_reg #(.W(N_CHAN)) u_cstat (
        .clk(clk), .rst(rst), .ev(cstat_ev), .clr_bits(cstat_clr), .q(cstat));

    cic_sticky_reg #(.W(NUM_OBJ)) u_txstat (
        .clk(clk), .rst(rst), .ev(ev_tx_done[OBJ_LAST:0]), .clr_bits(tx_clr), .q(tx_stat));

    cic_sticky_reg #(.W(NUM_OBJ)) u_rxstat (
        .clk(clk), .rst(rst), .ev(ev_rx_done[OBJ_LAST:0]), .clr_bits(rx_clr), .q(rx_stat));

    cic_irq_lines #(.NUM_OBJ(NUM_OBJ)) u_lines (
        .clk(clk), .rst(rst), .chan_stat(cstat), .chan_mask(cmask),
        .tx_stat(tx_stat), .rx_stat(rx_stat), .obj_mask(omask), .irq_q(irq_vec));

    assign irq_wake   = irq_vec[LN_WAKE];
    assign irq_err    = irq_vec[LN_ERR];
    assign irq_busoff = irq_vec[LN_BOFF];
    assign irq_tx     = irq_vec[LN_TX];
    assign irq_rx     = irq_vec[LN_RX];

    // Read path
    assign tx_pad = MAX_OBJ'(tx_stat);
    assign rx_pad = MAX_OBJ'(rx_stat);
    always_comb begin
        obj_rd.tx = tx_pad[reg_addr[3:0]];
        obj_rd.rx = rx_pad[reg_addr[3:0]];
        case (reg_addr)
            A_CMASK:  reg_rdata = DATA_W'(cmask);
            A_CSTAT:  reg_rdata = DATA_W'(cstat);
            A_OMASK:  reg_rdata = DATA_W'(omask);
            A_TXSTAT: reg_rdata = DATA_W'(tx_stat);
            A_RXSTAT: reg_rdata = DATA_W'(rx_stat);
            default:  reg_rdata = rd_obj ? DATA_W'(obj_rd) : '0;
        endcase
    end

    // R11
    obj_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_obj_clr && reg_wdata[0] && !ev_tx_done[reg_addr[3:0]])
        |=> !tx_pad[$past(reg_addr[3:0])]);

    // R7
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_CMASK) |=> $stable(cmask));

endmodule

// File: tb/sim_can_irq_ctrl.sv
module sim_can_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_we;
    logic [31:0] reg_rdata;
    logic        ev_wake, ev_err, ev_busoff;
    logic [15:0] ev_tx_done, ev_rx_done;
    logic        irq_wake, irq_err, irq_busoff, irq_tx, irq_rx;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Bench model of the register state, built from the requirements
    logic [4:0]  m_cmask;
    logic [2:0]  m_cstat;
    logic [15:0] m_omask, m_tx, m_rx;
    logic [4:0]  m_irq;

    always #10 clk = ~clk;   // 50 MHz

    can_irq_ctrl u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .ev_wake(ev_wake), .ev_err(ev_err),
        .ev_busoff(ev_busoff), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
        .irq_wake(irq_wake), .irq_err(irq_err), .irq_busoff(irq_busoff),
        .irq_tx(irq_tx), .irq_rx(irq_rx));

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return {27'd0, m_cmask};
            6'h03: return {29'd0, m_cstat};
            6'h05: return {16'd0, m_omask};
            6'h08: return {16'd0, m_tx};
            6'h0A: return {16'd0, m_rx};
            default:
                if (a[5:4] == 2'b01) return {30'd0, m_rx[a[3:0]], m_tx[a[3:0]]};
                else                 return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00, 6'h05: return "R7";
            6'h03, 6'h08, 6'h0A: return "R2";
            default: return (a[5:4] == 2'b01) ? "R11" : "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, check read data before the
    // rising edge, update the model at the edge, check request lines after it.
    task automatic step(input logic [5:0] a, input logic [31:0] d, input logic we,
                        input logic [2:0] cev, input logic [15:0] tev, input logic [15:0] rev);
        logic [4:0]  cs, cc;
        logic [2:0]  sc;
        logic [15:0] os, oc, tc, rc;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = we;
        {ev_busoff, ev_err, ev_wake} = cev;
        ev_tx_done = tev; ev_rx_done = rev;
        #2;
        check(tag_of(a), reg_rdata, exp_read(a));
        cs = 0; cc = 0; sc = 0; os = 0; oc = 0; tc = 0; rc = 0;
        if (we) begin
            case (a)
                6'h01: cs = d[4:0];
                6'h02: cc = d[4:0];
                6'h04: sc = d[2:0];
                6'h06: os = d[15:0];
                6'h07: oc = d[15:0];
                6'h09: tc = d[15:0];
                6'h0B: rc = d[15:0];
                default:
                    if (a[5:4] == 2'b10) begin
                        tc[a[3:0]] = d[0];
                        rc[a[3:0]] = d[1];
                    end
            endcase
        end
        @(posedge clk);
        m_irq   = {m_cmask[4] & |(m_rx & m_omask), m_cmask[3] & |(m_tx & m_omask),
                   m_cstat & m_cmask[2:0]};
        m_cmask = (m_cmask | cs) & ~cc;
        m_omask = (m_omask | os) & ~oc;
        m_cstat = (m_cstat & ~sc) | cev;
        m_tx    = (m_tx & ~tc) | tev;
        m_rx    = (m_rx & ~rc) | rev;
        #5;
        check("R8/R9/R10", {27'd0, irq_rx, irq_tx, irq_busoff, irq_err, irq_wake},
              {27'd0, m_irq});
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(a, d, 1'b1, 3'b0, 16'h0, 16'h0);
    endtask

    task automatic idle(input logic [5:0] a);
        step(a, 32'h0, 1'b0, 3'b0, 16'h0, 16'h0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [5:0] ra;
        void'($urandom(32'd4711));
        rst = 1'b1; reg_addr = 0; reg_wdata = 0; reg_we = 0;
        ev_wake = 0; ev_err = 0; ev_busoff = 0; ev_tx_done = 0; ev_rx_done = 0;
        m_cmask = 0; m_cstat = 0; m_omask = 0; m_tx = 0; m_rx = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #2;
        check("R1", {27'd0, irq_rx, irq_tx, irq_busoff, irq_err, irq_wake}, 32'd0);
        reg_addr = 6'h00; #1; check("R1", reg_rdata, 32'd0);
        reg_addr = 6'h05; #1; check("R1", reg_rdata, 32'd0);
        reg_addr = 6'h03; #1; check("R1", reg_rdata, 32'd0);
        reg_addr = 6'h08; #1; check("R1", reg_rdata, 32'd0);

        // R5: set alias, zeros ignored
        wr(6'h01, 32'h05);
        idle(6'h00); check("R5", reg_rdata, 32'h05);
        wr(6'h01, 32'h0);
        idle(6'h00); check("R5", reg_rdata, 32'h05);
        // R7: direct write to read-only mask address ignored
        wr(6'h00, 32'h1F);
        wr(6'h05, 32'hFFFF);
        idle(6'h00); check("R7", reg_rdata, 32'h05);
        idle(6'h05); check("R7", reg_rdata, 32'h0);
        // R6: clear alias
        wr(6'h02, 32'h01);
        idle(6'h00); check("R6", reg_rdata, 32'h04);

        // R2/R8: bus-off unmasked raises its line, error masked does not
        step(6'h03, 0, 0, 3'b110, 0, 0);
        idle(6'h03); check("R2", reg_rdata, 32'h6);
        check("R8", {30'd0, irq_busoff, irq_err}, 32'h2);
        // R3: zero clears ignored, one clears
        wr(6'h04, 32'h0);
        wr(6'h04, 32'h4);
        idle(6'h03); check("R3", reg_rdata, 32'h2);
        // R4: event and clear together, event wins
        step(6'h04, 32'h2, 1'b1, 3'b010, 0, 0);
        idle(6'h03); check("R4", reg_rdata, 32'h2);
        step(6'h09, 32'h8, 1'b1, 3'b0, 16'h0008, 0);
        idle(6'h08); check("R4", reg_rdata, 32'h8);

        // R9: transmit done on a masked-off object gives no request
        wr(6'h01, 32'h18);
        step(6'h00, 0, 0, 3'b0, 16'h0020, 0);
        idle(6'h00); check("R9", {31'd0, irq_tx}, 32'd0);
        wr(6'h06, 32'h0008);
        idle(6'h00); check("R9", {31'd0, irq_tx}, 32'd1);
        // R10: receive on object 3 with gate open
        step(6'h00, 0, 0, 3'b0, 0, 16'h0008);
        idle(6'h00); check("R10", {31'd0, irq_rx}, 32'd1);
        wr(6'h02, 32'h10);
        idle(6'h00); check("R10", {31'd0, irq_rx}, 32'd0);

        // R11: per-object read and clear
        idle(6'h13); check("R11", reg_rdata, 32'h3);
        wr(6'h23, 32'h1);
        idle(6'h13); check("R11", reg_rdata, 32'h2);
        idle(6'h15); check("R11", reg_rdata, 32'h1);
        // R12: write-only and unmapped reads are 0, unmapped write ignored
        idle(6'h01); check("R12", reg_rdata, 32'h0);
        wr(6'h3F, 32'hFFFF_FFFF);
        idle(6'h0C); check("R12", reg_rdata, 32'h0);

        // Constrained random traffic, every cycle checked against the model
        for (int k = 0; k < 4000; k++) begin
            logic [2:0]  ce;
            logic [15:0] te, re;
            ra = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 12);
            if ($urandom % 3 == 0) ra = {2'b01 + 2'($urandom % 2), 4'($urandom)};
            ce = ($urandom % 5 == 0) ? 3'($urandom) : 3'b0;
            te = ($urandom % 4 == 0) ? 16'($urandom & $urandom) : 16'h0;
            re = ($urandom % 4 == 0) ? 16'($urandom & $urandom) : 16'h0;
            step(ra, $urandom, 1'($urandom), ce, te, re);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule